// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Converter and Timer-Clock Sharing

This block is a seven-pin bidirectional general-purpose I/O port whose pins are also converter input channels and, for the top pin, the timer's external clock input. Software reaches two byte-wide registers over a simple bus with an address, a write strobe, a read strobe and an 8-bit data path. One register is an output data latch and the other is a per-pin direction register. From these registers and from the channel-select code and prescaler-select code that other blocks supply, the port produces the output enable and output level for each pad, the read-back byte, and a synchronized external timer clock.

A pin is in converter mode when the 5-bit channel-select code equals that pin's channel number. Pin k maps to channel 8 + k, so pins 0..6 are channels 8..14. A pin in converter mode never drives its pad, and its read-back bit no longer follows the pad level. The data latch can be written at any time. This lets software preload the output level before it turns a pin into an output.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is held, and for the whole of the following cycle, the direction register and the data latch are all zeros and every `pin_oe` bit is 0. A read of either register then returns 0x00 when all pads are low.
- R2: A write to offset 0x7 loads direction bits 6..0 from `bus_wdata[6:0]`. Bit 7 of this register always reads as 0, and writing a 1 to bit 7 has no effect.
- R3: A write to offset 0x3 loads the data latch from `bus_wdata[6:0]` at the clock edge, whatever the direction bits are. `pin_out` shows the latch and changes only after such a write.
- R4: `pin_oe[k]` is 1 exactly when direction bit k is 1 and pin k is not in converter mode. Converter mode for pin k means `chan_sel == 8 + k`.
- R5: When the data latch offset is read, the bit for a pin in converter mode is 0 if its direction bit is 0, and equals its latch bit if its direction bit is 1.
- R6: When the data latch offset is read, the bit for a pin not in converter mode equals its latch bit if its direction bit is 1. If its direction bit is 0, it equals the pad level captured through a two-stage synchronizer, so a pad change shows up after the second rising clock edge. Bit 7 reads as 0.
- R7: `bus_rdata` is 0x00 whenever `bus_rd` is low, and whenever the read offset is neither 0x3 nor 0x7. A write to any other offset changes neither register.
- R8: When `presc_sel` equals the external-clock code (default 3'b111), `ext_clk_sync` follows pad 6 through two synchronizing flops, two rising edges later. For any other code `ext_clk_sync` is 0.
- R9: A `chan_sel` value outside 8..14 puts no pin in converter mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, combinational read data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pin_in | input | 7 | Pad input levels |
| pin_out | output | 7 | Pad output levels (data latch) |
| pin_oe | output | 7 | Pad output enables |
| chan_sel | input | 5 | Converter channel-select code |
| presc_sel | input | 3 | Timer prescaler-select code |
| ext_clk_sync | output | 1 | Synchronized external timer clock from pad 6 |

## Verification
Some properties are checked on every cycle. No selected converter pin ever has its output enable set. Read data is zero when no read is strobed or the offset is unmapped. Direction bit 7 always reads back 0. The external clock output is quiet unless the external-clock code is selected. The pad output level only changes right after a write to the data latch. Other behaviours need the bench's scenarios. These are the per-pin read value chosen from the direction bit and the converter mode, the two-edge synchronizer latency on pad reads and on the timer clock, preloading the latch while the pins are inputs, and the out-of-range channel codes.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_DIR  = 2'd2
  } rsel_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_int_n = stage_q[1];
endmodule

// File: rtl/gpio_sync_bus.sv
module gpio_sync_bus #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NPIN   = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_we,
  input  logic              dir_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [NPIN-1:0]   latch_q,
  output logic [NPIN-1:0]   dir_q
);
  logic [NPIN-1:0] latch_d, dir_d;
  logic            unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:NPIN];

  always_comb begin
    latch_d = latch_q;
    dir_d   = dir_q;
    if (latch_we) latch_d = wdata[NPIN-1:0];
    if (dir_we)   dir_d   = wdata[NPIN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice (
  input  logic latch_bit,
  input  logic dir_bit,
  input  logic pad_sync,
  input  logic conv_mode,
  output logic oe,
  output logic rd_bit
);
  always_comb begin
    oe = dir_bit & ~conv_mode;
    if (dir_bit)        rd_bit = latch_bit;
    else if (conv_mode) rd_bit = 1'b0;
    else                rd_bit = pad_sync;
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int NPIN        = 7,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int CH_W        = 5,
  parameter int CH_BASE     = 8,
  parameter int PS_W        = 3,
  parameter int EXT_CLK_SEL = 7,
  parameter int LATCH_OFS   = 3,
  parameter int DIR_OFS     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [PS_W-1:0]   presc_sel,
  output logic              ext_clk_sync
);
  localparam int CLK_PIN = NPIN - 1;

  logic            rst_int_n;
  logic [NPIN-1:0] latch_q, dir_q, pad_sync, conv_mode, rd_bits;
  logic            latch_we, dir_we;
  rsel_e           rsel;

  gpio_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  gpio_sync_bus #(.W(NPIN)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (pin_in),
    .sync_out (pad_sync)
  );

  assign latch_we = bus_wr && (bus_addr == ADDR_W'(LATCH_OFS));
  assign dir_we   = bus_wr && (bus_addr == ADDR_W'(DIR_OFS));

  gpio_port_regs #(.NPIN(NPIN), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .latch_we (latch_we),
    .dir_we   (dir_we),
    .wdata    (bus_wdata),
    .latch_q  (latch_q),
    .dir_q    (dir_q)
  );

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    assign conv_mode[k] = (chan_sel == CH_W'(CH_BASE + k));
    gpio_pin_slice u_slice (
      .latch_bit (latch_q[k]),
      .dir_bit   (dir_q[k]),
      .pad_sync  (pad_sync[k]),
      .conv_mode (conv_mode[k]),
      .oe        (pin_oe[k]),
      .rd_bit    (rd_bits[k])
    );
  end

  assign pin_out = latch_q;

  always_comb begin
    rsel = RSEL_NONE;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(LATCH_OFS))    rsel = RSEL_DATA;
      else if (bus_addr == ADDR_W'(DIR_OFS)) rsel = RSEL_DIR;
    end
  end

  always_comb begin
    case (rsel)
      RSEL_DATA: bus_rdata = DATA_W'(rd_bits);
      RSEL_DIR:  bus_rdata = DATA_W'(dir_q);
      default:   bus_rdata = '0;
    endcase
  end

  assign ext_clk_sync = (presc_sel == PS_W'(EXT_CLK_SEL)) ? pad_sync[CLK_PIN] : 1'b0;
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int NPIN        = 7,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int CH_W        = 5,
  parameter int CH_BASE     = 8,
  parameter int PS_W        = 3,
  parameter int EXT_CLK_SEL = 7,
  parameter int LATCH_OFS   = 3,
  parameter int DIR_OFS     = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic [CH_W-1:0]   chan_sel,
  input logic [PS_W-1:0]   presc_sel,
  input logic              ext_clk_sync
);
  logic [NPIN-1:0] sel_vec;
  logic            latch_hit, unmapped;

  always_comb
    for (int k = 0; k < NPIN; k++) sel_vec[k] = (chan_sel == CH_W'(CH_BASE + k));

  assign latch_hit = bus_wr && (bus_addr == ADDR_W'(LATCH_OFS));
  assign unmapped  = (bus_addr != ADDR_W'(LATCH_OFS)) && (bus_addr != ADDR_W'(DIR_OFS));

  // R4
  conv_pin_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & sel_vec) == '0);

  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || unmapped) |-> (bus_rdata == '0));

  // R2
  dir_top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(DIR_OFS)) |-> (bus_rdata[DATA_W-1] == 1'b0));

  // R8
  ext_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_sel != PS_W'(EXT_CLK_SEL)) |-> (ext_clk_sync == 1'b0));

  // R3
  pad_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch_hit) |-> $stable(pin_out));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(
  .NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .CH_BASE(CH_BASE),
  .PS_W(PS_W), .EXT_CLK_SEL(EXT_CLK_SEL), .LATCH_OFS(LATCH_OFS), .DIR_OFS(DIR_OFS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .pin_out      (pin_out),
  .pin_oe       (pin_oe),
  .chan_sel     (chan_sel),
  .presc_sel    (presc_sel),
  .ext_clk_sync (ext_clk_sync)
);

// File: tb/gpio_mux_port_bench.sv
`timescale 1ns/1ps
module gpio_mux_port_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [6:0] pin_in, pin_out, pin_oe;
  logic [4:0] chan_sel;
  logic [2:0] presc_sel;
  logic       ext_clk_sync;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gpio_mux_port u_gpio_mux_port (.*);

  // {dir, latch, chan, pads, expected read, expected oe}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {7'h00, 7'h55, 5'd0,  7'h2A, 8'h2A, 7'h00},  // R6 inputs
    {7'h7F, 7'h55, 5'd0,  7'h2A, 8'h55, 7'h7F},  // R6 outputs
    {7'h0F, 7'h33, 5'd0,  7'h70, 8'h73, 7'h0F},  // R6 mixed
    {7'h00, 7'h7F, 5'd8,  7'h7F, 8'h7E, 7'h00},  // R5 pin0 conv, dir 0
    {7'h7F, 7'h41, 5'd14, 7'h00, 8'h41, 7'h3F},  // R5 R4 pin6 conv, dir 1
    {7'h70, 7'h0F, 5'd11, 7'h0F, 8'h07, 7'h70},  // R5 R4 pin3 conv
    {7'h00, 7'h00, 5'd15, 7'h7F, 8'h7F, 7'h00},  // R9 above range
    {7'h7F, 7'h2A, 5'd7,  7'h00, 8'h2A, 7'h7F}   // R9 below range
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    pin_in = '0; chan_sel = '0; presc_sel = '0;
    repeat (4) @(negedge clk);
    chk("R1 oe in reset", 32'(pin_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(4'h7, r); chk("R1 dir reset", 32'(r), 0);
    rd(4'h3, r); chk("R1 data reset", 32'(r), 0);
    chk("R1 latch reset", 32'(pin_out), 0);
    chk("R1 oe reset", 32'(pin_oe), 0);

    // R3: preload the latch while all pins are inputs
    wr(4'h3, 8'h6C);
    chk("R3 preload pin_out", 32'(pin_out), 32'h6C);
    chk("R3 preload oe off", 32'(pin_oe), 0);

    // R2: bit 7 ignored
    wr(4'h7, 8'hFF);
    rd(4'h7, r); chk("R2 dir readback", 32'(r), 32'h7F);
    chk("R4 all outputs", 32'(pin_oe), 32'h7F);

    // R7: unmapped offset write and read, idle read
    wr(4'h5, 8'h00);
    rd(4'h7, r); chk("R7 dir kept", 32'(r), 32'h7F);
    chk("R7 latch kept", 32'(pin_out), 32'h6C);
    rd(4'h5, r); chk("R7 unmapped read", 32'(r), 0);
    @(negedge clk); bus_addr = 4'h7; #1;
    chk("R7 no strobe", 32'(bus_rdata), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(4'h7, {1'b0, VEC[i][40:34]});
      wr(4'h3, {1'b0, VEC[i][33:27]});
      chan_sel = VEC[i][26:22];
      pin_in   = VEC[i][21:15];
      repeat (3) @(negedge clk);
      rd(4'h3, r);
      chk($sformatf("R5/R6/R9 read vec %0d", i), 32'(r), 32'(VEC[i][14:7]));
      chk($sformatf("R4/R9 oe vec %0d", i), 32'(pin_oe), 32'(VEC[i][6:0]));
    end

    // R6: two-edge synchronizer latency on pad reads
    chan_sel = 5'd0;
    wr(4'h7, 8'h00);
    @(negedge clk); pin_in = 7'h00;
    repeat (3) @(negedge clk);
    pin_in = 7'h15;
    @(negedge clk); bus_addr = 4'h3; bus_rd = 1'b1; #1;
    chk("R6 one edge old", 32'(bus_rdata), 0);
    @(negedge clk); #1;
    chk("R6 two edges new", 32'(bus_rdata), 32'h15);
    bus_rd = 1'b0;

    // R8: external clock routing
    presc_sel = 3'b111; pin_in = 7'h00;
    repeat (3) @(negedge clk);
    chk("R8 ext low", 32'(ext_clk_sync), 0);
    pin_in = 7'h40;
    @(negedge clk); chk("R8 one edge", 32'(ext_clk_sync), 0);
    @(negedge clk); chk("R8 two edges", 32'(ext_clk_sync), 1);
    presc_sel = 3'b011; #1;
    chk("R8 deselected", 32'(ext_clk_sync), 0);

    done = 1;
    finish_run();
  end
endmodule